// File: doc/BRIEF.md
# Replay-capable FIFO buffer

This block is a single-clock first-in first-out buffer whose read side can pin a position in the stream and later rewind to it, so that a run of words is delivered a second time. The consumer raises a mark strobe while it reads the first word of a block it may need to resend. If the receiver asks for a resend, the consumer pulls the active-low retransmit line low. The read pointer then jumps back to the pinned word, and every word from there up to the newest write is delivered again in order.

While a mark is held, the words between the mark and the write pointer are not released. The full flag counts them as occupied, so new writes can never overwrite data that may still be replayed. Raising the mark again at a later read position moves the pin forward and frees the older words. Two synchronous active-high resets are provided. The master reset clears everything, including the output register. The partial reset rewinds both pointers and drops the mark but leaves the last output word in place.

Top module: `mark_fifo`

## Requirements
- R1: A word on `wr_data` is stored at a rising clock edge where `wr_en_n` is 0 and `full` is 1'b0; stored words are later delivered in the order they were written.
- R2: At a rising edge where `rd_en_n` is 0, `empty` is 0 and no retransmit is taken, `rd_data` takes the oldest unread word right after that edge.
- R3: `empty` is 1 exactly when the read pointer equals the write pointer; a read request while empty leaves `rd_data` and the pointers unchanged.
- R4: `full` is 1 when DEPTH words lie between the retention floor (the mark if one is set, otherwise the read pointer) and the write pointer; a write request while full is dropped.
- R5: With `mark` at 1 on an edge that takes no retransmit, the read location at that edge (the word being read, if a read is taken) is stored as the mark; `mark` is ignored on an edge that takes a retransmit.
- R6: A retransmit is taken at an edge where `rexmit_n` is 0 and was 1 at the previous edge; it loads the read pointer with the mark, and holding `rexmit_n` low does not rewind again.
- R7: A retransmit has priority over a read requested at the same edge: `rd_data` is unchanged at that edge and the next read returns the marked word.
- R8: While a mark is set, reading does not free locations: words from the mark onward still count toward `full`.
- R9: A retransmit taken with no mark set since the last reset rewinds the read pointer to the first memory location (valid while fewer than DEPTH words were written since that reset).
- R10: After a retransmit, `empty` and `full` reflect the restored read pointer in the cycle that follows the edge.
- R11: Master reset `rst` (priority over `prst`) sets both pointers to the first location, clears the mark and sets `rd_data` to 0, giving `empty` 1 and `full` 0.
- R12: Partial reset `prst` sets both pointers to the first location and clears the mark but keeps `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| wr_en_n | input | 1 | Write request, active low |
| wr_data | input | DATA_W | Word to store |
| rd_en_n | input | 1 | Read request, active low |
| rd_data | output | DATA_W | Registered output word |
| mark | input | 1 | Record the current read location as the replay point |
| rexmit_n | input | 1 | Retransmit request, falling-edge sensitive, active low |
| empty | output | 1 | No unread word |
| full | output | 1 | No free location counting retained words |

## Verification
Fill levels from one word up to DEPTH are swept over several pointer laps, so a design that compares pointers without the wrap bit would raise full or empty at the wrong level once the address wraps. Marks are placed at every early read position and then replayed. An off-by-one mark capture would replay starting from the neighbouring word. A mark that did not hold back the floor would let new writes overwrite replay data. The bench also collides a retransmit with a read, with a mark strobe, and with a held-low request. A design that lets the read win, re-captures the mark, or rewinds on level instead of edge would return the wrong word. Finally, it checks that partial reset keeps the output word while master reset clears it.

// File: rtl/mark_fifo_pkg.sv
package mark_fifo_pkg;

    // Read-side action chosen each cycle.
    typedef enum logic [1:0] {
        RD_HOLD   = 2'd0,
        RD_POP    = 2'd1,
        RD_REWIND = 2'd2
    } rd_act_e;

    // Reset request seen this cycle; master dominates partial.
    typedef enum logic [1:0] {
        RS_NONE   = 2'd0,
        RS_PART   = 2'd1,
        RS_MASTER = 2'd2
    } rst_kind_e;

    function automatic rst_kind_e decode_reset(input logic master, input logic partial);
        if (master)
            return RS_MASTER;
        else if (partial)
            return RS_PART;
        return RS_NONE;
    endfunction

    // Rewind beats a read; a read needs data.
    function automatic rd_act_e pick_rd_act(input logic rewind_req,
                                            input logic pop_req,
                                            input logic is_empty);
        if (rewind_req)
            return RD_REWIND;
        else if (pop_req && !is_empty)
            return RD_POP;
        return RD_HOLD;
    endfunction

endpackage

// File: rtl/mark_fifo_store.sv
module mark_fifo_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              clr_out,
    input  logic              wr_fire,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_fire,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_fire)
            cells[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (clr_out)
            rd_data <= '0;
        else if (rd_fire)
            rd_data <= cells[rd_addr];
    end

endmodule

// File: rtl/mark_fifo_wr_ctl.sv
module mark_fifo_wr_ctl
    import mark_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  rst_kind_e     rkind,
    input  logic          wr_req,
    input  logic          full,
    output logic [PW-1:0] wptr,
    output logic          wr_fire
);

    assign wr_fire = (rkind == RS_NONE) && wr_req && !full;

    always_ff @(posedge clk) begin
        if (rkind != RS_NONE)
            wptr <= '0;
        else if (wr_fire)
            wptr <= wptr + PW'(1);
    end

    // R4: a write request against a full buffer leaves the write pointer alone
    a_r4_full_write_dropped: assert property (@(posedge clk)
        disable iff (rkind != RS_NONE)
        (full && wr_req) |=> $stable(wptr));

endmodule

// File: rtl/mark_fifo_rd_ctl.sv
module mark_fifo_rd_ctl
    import mark_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  rst_kind_e     rkind,
    input  logic          rd_req,
    input  logic          rexmit_n,
    input  logic          mark,
    input  logic          empty,
    output logic [PW-1:0] rptr,
    output logic [PW-1:0] floor_ptr,
    output rd_act_e       act
);

    logic          rex_prev;
    logic          mark_set;
    logic [PW-1:0] mark_ptr;
    logic          rewind_req;
    logic [PW-1:0] rewind_target;

    assign rewind_req    = rex_prev && !rexmit_n;
    assign rewind_target = mark_set ? mark_ptr : '0;
    assign floor_ptr     = mark_set ? mark_ptr : rptr;
    assign act           = (rkind == RS_NONE) ? pick_rd_act(rewind_req, rd_req, empty)
                                              : RD_HOLD;

    always_ff @(posedge clk) begin
        if (rkind != RS_NONE) begin
            rptr     <= '0;
            mark_set <= 1'b0;
            mark_ptr <= '0;
            rex_prev <= 1'b1;
        end else begin
            rex_prev <= rexmit_n;
            unique case (act)
                RD_REWIND: rptr <= rewind_target;
                RD_POP:    rptr <= rptr + PW'(1);
                default:   rptr <= rptr;
            endcase
            if (mark && act != RD_REWIND) begin
                mark_set <= 1'b1;
                mark_ptr <= rptr;
            end
        end
    end

    // R6: the read pointer lands on the rewind target
    a_r6_rewind_lands: assert property (@(posedge clk)
        disable iff (rkind != RS_NONE)
        (act == RD_REWIND) |=> (rptr == $past(rewind_target)));

    // R6: a held-low retransmit request does not rewind twice in a row
    a_r6_single_rewind: assert property (@(posedge clk)
        disable iff (rkind != RS_NONE)
        (act == RD_REWIND) |=> (act != RD_REWIND));

    // R5: a mark strobe on a non-rewind edge pins the read location
    a_r5_mark_capture: assert property (@(posedge clk)
        disable iff (rkind != RS_NONE)
        (mark && act != RD_REWIND) |=> (mark_set && mark_ptr == $past(rptr)));

    // R5: a mark strobe on a rewind edge leaves the stored mark untouched
    a_r5_mark_ignored: assert property (@(posedge clk)
        disable iff (rkind != RS_NONE)
        (act == RD_REWIND) |=> ($stable(mark_ptr) && $stable(mark_set)));

endmodule

// File: rtl/mark_fifo.sv
module mark_fifo
    import mark_fifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prst,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en_n,
    output logic [DATA_W-1:0] rd_data,
    input  logic              mark,
    input  logic              rexmit_n,
    output logic              empty,
    output logic              full
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    rst_kind_e     rkind;
    logic [PW-1:0] wptr;
    logic [PW-1:0] rptr;
    logic [PW-1:0] floor_ptr;
    logic [PW-1:0] held;
    logic          wr_fire;
    rd_act_e       act;

    assign rkind = decode_reset(rst, prst);
    assign held  = wptr - floor_ptr;
    assign empty = (rptr == wptr);
    assign full  = (held == DEPTH_P);

    mark_fifo_wr_ctl #(.DEPTH(DEPTH)) u_wr (
        .clk     (clk),
        .rkind   (rkind),
        .wr_req  (!wr_en_n),
        .full    (full),
        .wptr    (wptr),
        .wr_fire (wr_fire)
    );

    mark_fifo_rd_ctl #(.DEPTH(DEPTH)) u_rd (
        .clk       (clk),
        .rkind     (rkind),
        .rd_req    (!rd_en_n),
        .rexmit_n  (rexmit_n),
        .mark      (mark),
        .empty     (empty),
        .rptr      (rptr),
        .floor_ptr (floor_ptr),
        .act       (act)
    );

    mark_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .clr_out (rkind == RS_MASTER),
        .wr_fire (wr_fire),
        .wr_addr (wptr[AW-1:0]),
        .wr_data (wr_data),
        .rd_fire (act == RD_POP),
        .rd_addr (rptr[AW-1:0]),
        .rd_data (rd_data)
    );

    // R4 / R8: retained words never exceed the storage size
    a_r4_no_overflow: assert property (@(posedge clk)
        disable iff (rkind != RS_NONE)
        held <= DEPTH_P);

    // R3: a read request on an empty buffer leaves the output word unchanged
    a_r3_empty_read_quiet: assert property (@(posedge clk)
        disable iff (rkind != RS_NONE)
        (empty && act != RD_REWIND) |=> $stable(rd_data));

    // R12: partial reset rewinds both pointers and keeps the output word
    a_r12_partial_reset: assert property (@(posedge clk)
        disable iff (rst)
        prst |=> (rptr == '0 && wptr == '0 && $stable(rd_data)));

endmodule

// File: tb/test_mark_fifo.sv
module test_mark_fifo;

    localparam int DW = 8;
    localparam int DP = 8;

    logic          clk      = 1'b0;
    logic          rst      = 1'b1;
    logic          prst     = 1'b0;
    logic          wr_en_n  = 1'b1;
    logic [DW-1:0] wr_data  = '0;
    logic          rd_en_n  = 1'b1;
    logic [DW-1:0] rd_data;
    logic          mark     = 1'b0;
    logic          rexmit_n = 1'b1;
    logic          empty;
    logic          full;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    mark_fifo #(.DATA_W(DW), .DEPTH(DP)) i_mark_fifo (
        .clk      (clk),
        .rst      (rst),
        .prst     (prst),
        .wr_en_n  (wr_en_n),
        .wr_data  (wr_data),
        .rd_en_n  (rd_en_n),
        .rd_data  (rd_data),
        .mark     (mark),
        .rexmit_n (rexmit_n),
        .empty    (empty),
        .full     (full)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [DW-1:0] d);
        wr_en_n = 1'b0;
        wr_data = d;
        tick();
        wr_en_n = 1'b1;
    endtask

    task automatic pop_check(input logic [DW-1:0] exp, input string tag);
        rd_en_n = 1'b0;
        tick();
        rd_en_n = 1'b1;
        check(tag, 32'(rd_data), 32'(exp));
    endtask

    task automatic pop_mark_check(input logic [DW-1:0] exp, input string tag);
        rd_en_n = 1'b0;
        mark    = 1'b1;
        tick();
        rd_en_n = 1'b1;
        mark    = 1'b0;
        check(tag, 32'(rd_data), 32'(exp));
    endtask

    task automatic rexmit_pulse();
        rexmit_n = 1'b0;
        tick();
        rexmit_n = 1'b1;
    endtask

    task automatic part_reset();
        prst = 1'b1;
        tick();
        prst = 1'b0;
    endtask

    initial begin
        logic [DW-1:0] last;
        repeat (2) tick();
        rst = 1'b0;
        // R11: state right after master reset
        check("R11 empty after reset", 32'(empty), 32'd1);
        check("R11 full after reset", 32'(full), 32'd0);
        check("R11 rd_data after reset", 32'(rd_data), 32'd0);

        // R1-style sweep over fill levels, crossing several pointer laps
        for (int n = 1; n <= DP; n++) begin
            for (int k = 0; k < n; k++) push(8'(n * 20 + k));
            check("R1 not empty after writes", 32'(empty), 32'd0);
            check("R4 full at level", 32'(full), 32'(n == DP));
            if (n == DP) begin
                push(8'hFF); // R4: dropped
                check("R4 still full after dropped write", 32'(full), 32'd1);
            end
            for (int k = 0; k < n; k++) pop_check(8'(n * 20 + k), "R2 fifo order");
            check("R3 empty after drain", 32'(empty), 32'd1);
            last = 8'(n * 20 + n - 1);
            rd_en_n = 1'b0;
            tick();
            rd_en_n = 1'b1;
            check("R3 read on empty keeps rd_data", 32'(rd_data), 32'(last));
            check("R3 still empty", 32'(empty), 32'd1);
        end

        // R5 / R6 / R10: mark at each early position, then replay
        for (int m = 0; m < 4; m++) begin
            part_reset();
            for (int k = 0; k < 6; k++) push(8'(8'hA0 + m * 8 + k));
            for (int k = 0; k < m; k++) pop_check(8'(8'hA0 + m * 8 + k), "R2 before mark");
            pop_mark_check(8'(8'hA0 + m * 8 + m), "R5 marked read");
            for (int k = m + 1; k < 6; k++) pop_check(8'(8'hA0 + m * 8 + k), "R2 after mark");
            check("R3 empty before replay", 32'(empty), 32'd1);
            rexmit_pulse();
            check("R10 not empty after rewind", 32'(empty), 32'd0);
            for (int k = m; k < 6; k++) pop_check(8'(8'hA0 + m * 8 + k), "R6 replay word");
            check("R3 empty after replay", 32'(empty), 32'd1);
            last = 8'(8'hA0 + m * 8 + 5);
            part_reset();
            check("R12 rd_data kept by partial reset", 32'(rd_data), 32'(last));
            check("R12 empty after partial reset", 32'(empty), 32'd1);
        end

        // R8: a held mark keeps read words counted toward full
        part_reset();
        for (int k = 0; k < 4; k++) push(8'(8'h30 + k));
        mark = 1'b1;
        tick();
        mark = 1'b0;
        for (int k = 0; k < 4; k++) pop_check(8'(8'h30 + k), "R2 drain with mark");
        for (int k = 4; k < 8; k++) push(8'(8'h30 + k));
        check("R8 full counts from mark", 32'(full), 32'd1);
        check("R8 not empty", 32'(empty), 32'd0);
        push(8'hEE); // R4: dropped
        rexmit_pulse();
        check("R10 full after rewind", 32'(full), 32'd1);
        for (int k = 0; k < 8; k++) pop_check(8'(8'h30 + k), "R8 retained replay");
        check("R4 dropped write absent", 32'(empty), 32'd1);

        // R8 contrast: without a mark the same pattern is not full
        part_reset();
        for (int k = 0; k < 4; k++) push(8'(8'h40 + k));
        for (int k = 0; k < 4; k++) pop_check(8'(8'h40 + k), "R2 drain no mark");
        for (int k = 0; k < 4; k++) push(8'(8'h44 + k));
        check("R8 no mark frees space", 32'(full), 32'd0);

        // R7: retransmit wins over a read at the same edge
        part_reset();
        for (int k = 0; k < 3; k++) push(8'(8'h50 + k));
        pop_mark_check(8'h50, "R5 mark at first word");
        pop_check(8'h51, "R2 second word");
        rexmit_n = 1'b0;
        rd_en_n  = 1'b0;
        tick();
        rd_en_n  = 1'b1;
        rexmit_n = 1'b1;
        check("R7 rd_data unchanged on rewind edge", 32'(rd_data), 32'h51);
        pop_check(8'h50, "R7 next read is marked word");
        // R6: held low rewinds only once
        rexmit_n = 1'b0;
        tick();
        rd_en_n = 1'b0;
        tick();
        check("R6 held low first", 32'(rd_data), 32'h50);
        tick();
        check("R6 held low second", 32'(rd_data), 32'h51);
        tick();
        check("R6 held low third", 32'(rd_data), 32'h52);
        rd_en_n  = 1'b1;
        rexmit_n = 1'b1;
        tick();

        // R5: a mark strobe on a rewind edge is ignored
        part_reset();
        for (int k = 0; k < 6; k++) push(8'(8'h60 + k));
        pop_check(8'h60, "R2 pre");
        pop_check(8'h61, "R2 pre");
        pop_mark_check(8'h62, "R5 mark at third");
        pop_check(8'h63, "R2 post");
        pop_check(8'h64, "R2 post");
        rexmit_n = 1'b0;
        mark     = 1'b1;
        tick();
        rexmit_n = 1'b1;
        mark     = 1'b0;
        pop_check(8'h62, "R6 rewind with mark strobe");
        pop_check(8'h63, "R2 after rewind");
        rexmit_pulse();
        pop_check(8'h62, "R5 mark unchanged by rewind edge strobe");

        // R9: retransmit with no mark goes to the first location
        part_reset();
        for (int k = 0; k < 5; k++) push(8'(8'h70 + k));
        for (int k = 0; k < 3; k++) pop_check(8'(8'h70 + k), "R2 pre no-mark");
        rexmit_pulse();
        pop_check(8'h70, "R9 rewind to first location");

        // R11: master reset mid-stream
        push(8'h99);
        rst = 1'b1;
        prst = 1'b1;
        tick();
        rst = 1'b0;
        prst = 1'b0;
        check("R11 rd_data cleared", 32'(rd_data), 32'd0);
        check("R11 empty", 32'(empty), 32'd1);
        check("R11 not full", 32'(full), 32'd0);
        push(8'h5A);
        pop_check(8'h5A, "R11 works after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule